// File: doc/BRIEF.md
# RAM ECC Error Event Monitor

This block sits beside a RAM ECC checker and turns its per-access error reports into software-visible state. Three kinds of report arrive as one-cycle pulses: a corrected single-bit fault seen on a read, an uncorrectable double-bit fault seen on a read, and a double-bit fault seen while a partial (byte) write merges into a stored word. Each pulse comes with the address, the data word and the check code of the access.

Every kind sets its own sticky flag. The interrupt line is the OR of each flag gated by that kind's interrupt enable. One shared saturating occurrence counter advances when an enabled kind fires. A context latch, which software can turn on or off, keeps the address, data and code of the first read error. It keeps them until software clears both read flags. A 2-bit test-access field drives two blocking outputs, one that fences the data array and one that fences the check-code array.

Software reaches the block through a plain word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the stored state.

Top module: `ecc_evt_mon`

## Requirements
- R1: After reset the control word, the status flags, the counter and the context registers read 0, `irq` is 0, and both blocking outputs are 0.
- R2: The status word (offset 1) holds a sticky flag per kind: bit 0 for a read single error, bit 1 for a read double error, bit 2 for a byte-write double error. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. An event arriving in the same cycle as its clear leaves the flag set.
- R3: `irq` is high exactly when some status flag is set and its interrupt enable is set. The enables sit in control word (offset 0) bits 0, 1 and 2, in the same kind order as the status bits.
- R4: The counter (offset 2) adds one in each cycle in which at least one event kind fires with its counter enable set. The enables sit in control bits 4, 5 and 6, in the same kind order. Several kinds firing in one cycle still add only one.
- R5: The counter saturates at all-ones and does not wrap.
- R6: Writing zero to the counter offset clears it. A nonzero write to that offset is ignored.
- R7: When control bit 3 is 1, a read single or read double error captures address, data and code into offsets 3, 4 and 5, provided neither read flag is already set.
- R8: While either read flag is set, the context registers do not change.
- R9: A byte-write double error never changes the context registers.
- R10: Control bits 8:7 select the test mode. Value 1 raises `blk_data`. Value 2 raises `blk_code`. Values 0 and 3 raise neither.
- R11: When control bit 3 is 0, read errors leave the context registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rse | input | 1 | Read single-error pulse |
| ev_rde | input | 1 | Read double-error pulse |
| ev_bwe | input | 1 | Byte-write double-error pulse |
| ev_addr | input | ADDR_W | Address of the reported access |
| ev_data | input | DATA_W | Data word of the reported access |
| ev_code | input | CODE_W | Check code of the reported access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Level interrupt |
| blk_data | output | 1 | Block access to the data array |
| blk_code | output | 1 | Block access to the check-code array |

## Verification
The assertions assume that the event pulses and the register strobe are clean and valid only in cycles after reset. They also assume that a control write in the same cycle as an event may change the enables before they take effect, so the interrupt property excludes such cycles. The stimulus changes inputs only on the falling clock edge, holds each pulse for exactly one cycle, and uses a narrow counter so saturation is reachable within a short run.

// File: rtl/ecc_evt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the ECC error event monitor.
// Assumes a 32-bit register port with word offsets.
package ecc_evt_pkg;
    localparam int NUM_EV = 3;
    localparam int EV_RSE = 0;
    localparam int EV_RDE = 1;
    localparam int EV_BWE = 2;
    localparam int REG_DW = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CNT   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CADDR = 3'd3;
    localparam logic [REG_AW-1:0] OFS_CDATA = 3'd4;
    localparam logic [REG_AW-1:0] OFS_CCODE = 3'd5;

    typedef enum logic [1:0] {
        TM_NONE     = 2'd0,
        TM_FENCE_DT = 2'd1,
        TM_FENCE_CK = 2'd2,
        TM_NONE_ALT = 2'd3
    } tmode_e;

    // Control word layout, LSB first: irq_en[2:0], ctx_en[3], cnt_en[6:4], tmode[8:7]
    typedef struct packed {
        tmode_e              tmode;
        logic [NUM_EV-1:0]   cnt_en;
        logic                ctx_en;
        logic [NUM_EV-1:0]   irq_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/ecc_evt_regs.sv
`timescale 1ns/1ps
// Control word, sticky status flags and test-mode decode.
// Assumes event pulses are one cycle wide; set has priority over clear.
module ecc_evt_regs
    import ecc_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_stat,
    input  logic [CFG_W-1:0]     ctrl_wdata,
    input  logic [NUM_EV-1:0]    stat_wdata,
    input  logic [NUM_EV-1:0]    ev,
    output cfg_t                 cfg_q,
    output logic [NUM_EV-1:0]    flag_q,
    output logic                 blk_data,
    output logic                 blk_code
);
    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (wr_ctrl) cfg_q <= cfg_t'(ctrl_wdata);
    end

    // One sticky, write-one-to-clear flag per event kind.
    for (genvar k = 0; k < NUM_EV; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[k] <= 1'b0;
            else        flag_q[k] <= ev[k] | (flag_q[k] & ~(wr_stat & stat_wdata[k]));
        end
    end

    // Test-access decode into the two fence outputs.
    always_comb begin
        blk_data = 1'b0;
        blk_code = 1'b0;
        case (cfg_q.tmode)
            TM_FENCE_DT: blk_data = 1'b1;
            TM_FENCE_CK: blk_code = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ecc_evt_cnt.sv
`timescale 1ns/1ps
// Saturating occurrence counter with a synchronous clear.
// Assumes clear and increment never need to both apply; clear wins.
module ecc_evt_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count enabled events, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 cnt_q <= '0;
        else if (hit && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ecc_evt_ctx.sv
`timescale 1ns/1ps
// Error context latch: keeps address, data and code of the first read error.
// Assumes 'hold' is high while an earlier capture is still unacknowledged.
module ecc_evt_ctx #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd_err,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [CODE_W-1:0] code_q
);
    // Capture once per acknowledged window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            code_q <= '0;
        end else if (en && rd_err && !hold) begin
            addr_q <= addr;
            data_q <= data;
            code_q <= code;
        end
    end
endmodule

// File: rtl/ecc_evt_mon.sv
`timescale 1ns/1ps
// Top of the ECC error event monitor: register decode, interrupt level,
// counter and context latch. Assumes ADDR_W, DATA_W, CODE_W, CNT_W <= 32.
module ecc_evt_mon
    import ecc_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CODE_W = 7,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rse,
    input  logic              ev_rde,
    input  logic              ev_bwe,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              blk_data,
    output logic              blk_code
);
    logic [NUM_EV-1:0] ev;
    cfg_t              cfg_q;
    logic [NUM_EV-1:0] flag_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] ctx_addr_q;
    logic [DATA_W-1:0] ctx_data_q;
    logic [CODE_W-1:0] ctx_code_q;
    logic              cnt_clr;

    assign ev      = {ev_bwe, ev_rde, ev_rse};
    assign cnt_clr = reg_we && (reg_addr == OFS_CNT) && (reg_wdata == '0);
    assign irq     = |(flag_q & cfg_q.irq_en);

    ecc_evt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (reg_we && reg_addr == OFS_CTRL),
        .wr_stat    (reg_we && reg_addr == OFS_STAT),
        .ctrl_wdata (reg_wdata[CFG_W-1:0]),
        .stat_wdata (reg_wdata[NUM_EV-1:0]),
        .ev         (ev),
        .cfg_q      (cfg_q),
        .flag_q     (flag_q),
        .blk_data   (blk_data),
        .blk_code   (blk_code)
    );

    ecc_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (|(ev & cfg_q.cnt_en)),
        .clr   (cnt_clr),
        .cnt_q (cnt_q)
    );

    ecc_evt_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_q.ctx_en),
        .rd_err (ev_rse | ev_rde),
        .hold   (flag_q[EV_RSE] | flag_q[EV_RDE]),
        .addr   (ev_addr),
        .data   (ev_data),
        .code   (ev_code),
        .addr_q (ctx_addr_q),
        .data_q (ctx_data_q),
        .code_q (ctx_code_q)
    );

    // Read-back multiplexer, zero-extended to the port width.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata[CFG_W-1:0]  = cfg_q;
            OFS_STAT:  reg_rdata[NUM_EV-1:0] = flag_q;
            OFS_CNT:   reg_rdata[CNT_W-1:0]  = cnt_q;
            OFS_CADDR: reg_rdata[ADDR_W-1:0] = ctx_addr_q;
            OFS_CDATA: reg_rdata[DATA_W-1:0] = ctx_data_q;
            OFS_CCODE: reg_rdata[CODE_W-1:0] = ctx_code_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/ecc_evt_mon_chk.sv
`timescale 1ns/1ps
// Property checker for the ECC error event monitor, bound to the top.
// Assumes inputs are known from the first clock after reset is released.
module ecc_evt_mon_chk
    import ecc_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CODE_W = 7,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EV-1:0] ev,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [NUM_EV-1:0] irq_en,
    input logic [NUM_EV-1:0] flags,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] ctx_addr,
    input logic [DATA_W-1:0] ctx_data,
    input logic [CODE_W-1:0] ctx_code,
    input logic              irq,
    input logic              blk_data,
    input logic              blk_code
);
    logic              clr_w, ctrl_w;
    logic [NUM_EV-1:0] keep;

    assign clr_w  = reg_we && reg_addr == OFS_CNT && reg_wdata == '0;
    assign ctrl_w = reg_we && reg_addr == OFS_CTRL;
    assign keep   = flags & ~((reg_we && reg_addr == OFS_STAT) ? reg_wdata[NUM_EV-1:0] : '0);

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(keep)) == $past(keep)));
    assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & irq_en)) && !ctrl_w |=> irq);
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_w |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
    assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) && !clr_w |=> (&cnt));
    assert_cnt_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> cnt == '0);
    assert_ctx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[EV_RSE] || flags[EV_RDE]) |=>
        $stable(ctx_addr) && $stable(ctx_data) && $stable(ctx_code));
    assert_ctx_bw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_BWE] && !ev[EV_RSE] && !ev[EV_RDE] |=>
        $stable(ctx_addr) && $stable(ctx_data) && $stable(ctx_code));
    assert_fence_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_data && blk_code));
endmodule

bind ecc_evt_mon ecc_evt_mon_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_en    (cfg_q.irq_en),
    .flags     (flag_q),
    .cnt       (cnt_q),
    .ctx_addr  (ctx_addr_q),
    .ctx_data  (ctx_data_q),
    .ctx_code  (ctx_code_q),
    .irq       (irq),
    .blk_data  (blk_data),
    .blk_code  (blk_code)
);

// File: tb/ecc_evt_mon_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the ECC error event monitor; narrow counter for saturation.
module ecc_evt_mon_tb_top;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rse = 0, ev_rde = 0, ev_bwe = 0;
    logic [31:0] ev_addr = '0, ev_data = '0;
    logic [6:0]  ev_code = '0;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, blk_data, blk_code;
    int          n_tests = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    ecc_evt_mon #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_rse(ev_rse), .ev_rde(ev_rde), .ev_bwe(ev_bwe),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_code(ev_code),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .blk_data(blk_data), .blk_code(blk_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d, input logic [6:0] c);
        {ev_bwe, ev_rde, ev_rse} = k; ev_addr = a; ev_data = d; ev_code = c;
        @(negedge clk);
        {ev_bwe, ev_rde, ev_rse} = 3'b000;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v); chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 fences", {30'b0, blk_data, blk_code}, 0);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        pulse(3'b001, 0, 0, 0); rd(1, v); chk("R2 set rse", v, 32'h1);
        pulse(3'b100, 0, 0, 0); rd(1, v); chk("R2 set bwe", v, 32'h5);
        wr(1, 32'h1); rd(1, v); chk("R2 w1c", v, 32'h4);
        reg_we = 1; reg_addr = 1; reg_wdata = 32'h4; ev_bwe = 1;
        @(negedge clk);
        reg_we = 0; ev_bwe = 0;
        rd(1, v); chk("R2 set beats clear", v, 32'h4);
        wr(1, 32'h7); rd(1, v); chk("R2 clear all", v, 32'h0);
    endtask

    task automatic t_irq;
        wr(0, 32'h2);
        pulse(3'b001, 0, 0, 0); chk("R3 masked kind", {31'b0, irq}, 0);
        pulse(3'b010, 0, 0, 0); chk("R3 enabled kind", {31'b0, irq}, 1);
        wr(1, 32'h2); chk("R3 flag cleared", {31'b0, irq}, 0);
        wr(0, 32'h1); chk("R3 level on enable", {31'b0, irq}, 1);
        wr(1, 32'h7); chk("R3 all clear", {31'b0, irq}, 0);
        wr(0, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        wr(0, 32'h30); wr(2, 32'h0);
        pulse(3'b100, 0, 0, 0); rd(2, v); chk("R4 disabled kind", v, 0);
        pulse(3'b001, 0, 0, 0); rd(2, v); chk("R4 single", v, 1);
        pulse(3'b111, 0, 0, 0); rd(2, v); chk("R4 same cycle adds one", v, 2);
        wr(0, 32'h70);
        pulse(3'b100, 0, 0, 0); rd(2, v); chk("R4 bwe enabled", v, 3);
        wr(2, 32'h5); rd(2, v); chk("R6 nonzero write ignored", v, 3);
        wr(2, 32'h0); rd(2, v); chk("R6 zero clears", v, 0);
        wr(0, 32'h10);
        for (int i = 0; i < 17; i++) pulse(3'b001, 0, 0, 0);
        rd(2, v); chk("R5 saturates", v, 32'hF);
        wr(2, 32'h0); wr(0, 32'h0); wr(1, 32'h7);
    endtask

    task automatic t_ctx;
        logic [31:0] v;
        pulse(3'b001, 32'h44, 32'h99, 7'h3); rd(3, v); chk("R11 latch off", v, 0);
        wr(1, 32'h7); wr(0, 32'h8);
        pulse(3'b010, 32'h100, 32'hDEADBEEF, 7'h5A);
        rd(3, v); chk("R7 addr", v, 32'h100);
        rd(4, v); chk("R7 data", v, 32'hDEADBEEF);
        rd(5, v); chk("R7 code", v, 32'h5A);
        pulse(3'b001, 32'h200, 32'h1234, 7'h11);
        rd(3, v); chk("R8 addr frozen", v, 32'h100);
        rd(4, v); chk("R8 data frozen", v, 32'hDEADBEEF);
        wr(1, 32'h3);
        pulse(3'b001, 32'h200, 32'h1234, 7'h11);
        rd(3, v); chk("R7 recapture addr", v, 32'h200);
        rd(5, v); chk("R7 recapture code", v, 32'h11);
        wr(1, 32'h7);
        pulse(3'b100, 32'h300, 32'h55, 7'h22);
        rd(3, v); chk("R9 bw addr", v, 32'h200);
        rd(4, v); chk("R9 bw data", v, 32'h1234);
        wr(0, 32'h0);
    endtask

    task automatic t_tmode;
        for (int m = 0; m < 4; m++) begin
            wr(0, 32'(m) << 7);
            chk("R10 fence data", {31'b0, blk_data}, {31'b0, m == 1});
            chk("R10 fence code", {31'b0, blk_code}, {31'b0, m == 2});
        end
        wr(0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_flags(); t_irq(); t_count(); t_ctx(); t_tmode();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule